// File: doc/BRIEF.md
# Indirect Device Register Access Bridge

This block lets a narrow management register space (32 indices, 16-bit data) reach a much larger register space spread over up to 32 devices. Software first writes an access-control word naming a target device and an access function. It then uses a single data index, either to set a per-device register pointer or to move data through that pointer. In the data functions the pointer may step forward by one after each access.

The block sits behind a simple register slave port. The port carries an index, write data, a write strobe, a read strobe, read data, a one-cycle completion pulse and a busy flag. On the far side it drives a device port with a device number, a 16-bit register address, one-cycle read and write strobes, write data and an acknowledge that returns read data. Register-only accesses finish in one cycle. An access that reaches a device stays open until that device acknowledges.

Top module: `indirect_devreg_bridge`

## Requirements
- R1: A write to index 0x0D sets the access-control word. Bits 4:0 hold the device number and bits 15:14 hold the function code. A read of 0x0D returns the last value written, with bits 13:5 reading as zero.
- R2: An access that does not reach the device port (index 0x0D, index 0x0E with function 00, or any other index) raises the completion pulse in the cycle after the request is sampled. Read data is valid alongside that pulse.
- R3: With function 00, a write to index 0x0E loads the selected device's stored register address. A read of 0x0E returns that stored address. Neither access strobes the device port.
- R4: With function 01, each access to 0x0E issues exactly one device strobe carrying the device number and the current stored address. The stored address is left unchanged.
- R5: With function 10, the stored address steps by one after every device read and every device write. It wraps from 0xFFFF to 0x0000.
- R6: With function 11, the stored address steps by one after device writes and stays put after device reads.
- R7: Each of the 32 device numbers keeps its own stored address. Changing one device's address leaves the others untouched.
- R8: The device strobe lasts one cycle and is issued in the cycle after the request. Busy stays high until the acknowledge is sampled, and the completion pulse, with read data, follows one cycle after the acknowledge. Requests that arrive while busy is high are ignored.
- R9: Reset clears the access-control word and every stored address to zero.
- R10: Writes to any other index have no effect, and reads of any other index return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_addr | input | 5 | Management register index |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_wr | input | 1 | Management write request |
| mgmt_rd | input | 1 | Management read request |
| mgmt_rdata | output | 16 | Read data, valid with mgmt_done |
| mgmt_done | output | 1 | One-cycle completion pulse |
| mgmt_busy | output | 1 | High while a device access is open |
| dev_sel | output | 5 | Target device number |
| dev_reg | output | 16 | Target register address |
| dev_wr | output | 1 | Device write strobe |
| dev_rd | output | 1 | Device read strobe |
| dev_wdata | output | 16 | Device write data |
| dev_ack | input | 1 | Device acknowledge |
| dev_rdata | input | 16 | Device read data, valid with dev_ack |

## Verification
Register-only accesses give their completion pulse one cycle after the request edge. A device access shows its strobe one cycle after the request, and its completion two cycles after that plus the acknowledge delay. The bench counts cycles from the request edge to the pulse and compares the count with these figures for each access. It samples every output on the falling edge, records each strobe's device number, address and data as it appears, and checks the address steps by reading the pointer back in function 00.

// File: rtl/idb_pkg.sv
// Package: shared widths, the function code encoding and sequencer states
// for the indirect device register bridge.
package idb_pkg;
    localparam int DEV_W  = 5;   // device number width
    localparam int DATA_W = 16;  // data and register address width
    localparam int IDX_W  = 5;   // management index width

    // Function code held in the top two bits of the access-control word.
    typedef enum logic [1:0] {
        FN_ADDR   = 2'b00,  // data index reaches the stored pointer
        FN_FIXED  = 2'b01,  // device access, pointer kept
        FN_INC_RW = 2'b10,  // device access, pointer steps after read and write
        FN_INC_WR = 2'b11   // device access, pointer steps after write only
    } fn_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/idb_ctrl_reg.sv
// Module: idb_ctrl_reg
// Holds the access-control word: a function code and a device number.
// Assumes the caller qualifies wr_en with an accepted write to the control
// index. The read value places the function in the top two bits and the
// device number in the low bits, with the bits between them read as zero.
module idb_ctrl_reg #(
    parameter int DEV_W  = idb_pkg::DEV_W,
    parameter int DATA_W = idb_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        fn_in,
    input  logic [DEV_W-1:0]  dev_in,
    output idb_pkg::fn_e      fn,
    output logic [DEV_W-1:0]  dev,
    output logic [DATA_W-1:0] rd_value
);
    import idb_pkg::*;

    localparam int GAP_W = DATA_W - 2 - DEV_W;

    fn_e             fn_q;
    logic [DEV_W-1:0] dev_q;

    // Capture function and device on a control write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_q  <= FN_ADDR;
            dev_q <= '0;
        end else if (wr_en) begin
            fn_q  <= fn_e'(fn_in);
            dev_q <= dev_in;
        end
    end

    // Present the stored fields and the zero-filled read image.
    always_comb begin
        fn       = fn_q;
        dev      = dev_q;
        rd_value = {fn_q, {GAP_W{1'b0}}, dev_q};
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dev == $past(dev_in)) && (fn == $past(fn_in))); // R1
endmodule

// File: rtl/idb_addr_store.sv
// Module: idb_addr_store
// Keeps one register pointer per device number. A single update port
// writes the pointer of the selected device; the selected pointer is
// always visible on cur. Assumes sel is stable while an update is pending.
module idb_addr_store #(
    parameter int DEV_W  = idb_pkg::DEV_W,
    parameter int DATA_W = idb_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  sel,
    input  logic              upd,
    input  logic [DATA_W-1:0] upd_val,
    output logic [DATA_W-1:0] cur
);
    localparam int NDEV = 1 << DEV_W;

    logic [NDEV-1:0][DATA_W-1:0] slot_q;

    for (genvar g = 0; g < NDEV; g++) begin : g_slot
        // One pointer register per device; loads only when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (upd && (sel == DEV_W'(g))) begin
                slot_q[g] <= upd_val;
            end
        end
    end

    // Pick the selected device's pointer.
    always_comb cur = slot_q[sel];

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(slot_q)); // R7
endmodule

// File: rtl/idb_seq.sv
// Module: idb_seq
// Accepts management requests, serves the control and data indices,
// runs the device-port handshake and decides pointer updates.
// Assumes a device acknowledge arrives only while an access is open;
// requests seen while busy are dropped.
module idb_seq #(
    parameter int IDX_W    = idb_pkg::IDX_W,
    parameter int DATA_W   = idb_pkg::DATA_W,
    parameter int CTRL_IDX = 13,
    parameter int DATA_IDX = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  mgmt_addr,
    input  logic [DATA_W-1:0] mgmt_wdata,
    input  logic              mgmt_wr,
    input  logic              mgmt_rd,
    output logic [DATA_W-1:0] mgmt_rdata,
    output logic              mgmt_done,
    output logic              mgmt_busy,
    input  idb_pkg::fn_e      fn,
    input  logic [DATA_W-1:0] ctrl_value,
    input  logic [DATA_W-1:0] cur_addr,
    output logic              ctrl_wr_en,
    output logic              st_upd,
    output logic [DATA_W-1:0] st_val,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic              dev_ack,
    input  logic [DATA_W-1:0] dev_rdata
);
    import idb_pkg::*;

    seq_state_e        state_q;
    logic              op_wr_q;
    logic              accept, is_wr, hit_ctrl, hit_data, go_dev, finish, bump;
    logic [DATA_W-1:0] local_rd;

    // Decode the incoming request and the completion of an open access.
    always_comb begin
        accept   = (state_q == ST_IDLE) && (mgmt_wr || mgmt_rd);
        is_wr    = mgmt_wr;
        hit_ctrl = (mgmt_addr == IDX_W'(CTRL_IDX));
        hit_data = (mgmt_addr == IDX_W'(DATA_IDX));
        go_dev   = accept && hit_data && (fn != FN_ADDR);
        finish   = (state_q == ST_WAIT) && dev_ack;
        bump     = (fn == FN_INC_RW) || ((fn == FN_INC_WR) && op_wr_q);
        mgmt_busy  = (state_q == ST_WAIT);
        ctrl_wr_en = accept && is_wr && hit_ctrl;
    end

    // Choose read data for accesses answered without the device port.
    always_comb begin
        if (hit_ctrl)      local_rd = ctrl_value;
        else if (hit_data) local_rd = cur_addr;
        else               local_rd = '0;
    end

    // Pointer update: direct load in function 00, step after a finished access.
    always_comb begin
        st_upd = 1'b0;
        st_val = cur_addr;
        if (accept && is_wr && hit_data && (fn == FN_ADDR)) begin
            st_upd = 1'b1;
            st_val = mgmt_wdata;
        end else if (finish && bump) begin
            st_upd = 1'b1;
            st_val = cur_addr + DATA_W'(1);
        end
    end

    // Handshake state, one-cycle device strobes and the captured write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_wr_q   <= 1'b0;
            dev_wr    <= 1'b0;
            dev_rd    <= 1'b0;
            dev_wdata <= '0;
        end else begin
            dev_wr <= go_dev && is_wr;
            dev_rd <= go_dev && !is_wr;
            if (go_dev) begin
                state_q   <= ST_WAIT;
                op_wr_q   <= is_wr;
                dev_wdata <= mgmt_wdata;
            end else if (finish) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // Completion pulse and read data towards the management side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgmt_done  <= 1'b0;
            mgmt_rdata <= '0;
        end else begin
            mgmt_done <= (accept && !go_dev) || finish;
            if (accept && !go_dev) begin
                mgmt_rdata <= is_wr ? '0 : local_rd;
            end else if (finish) begin
                mgmt_rdata <= op_wr_q ? '0 : dev_rdata;
            end
        end
    end

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_wr && dev_rd)); // R8
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr || dev_rd) |=> !(dev_wr || dev_rd)); // R8
    AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr || dev_rd) |-> mgmt_busy); // R8
    AST_ADDR_MODE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (fn == FN_ADDR)) |=> !(dev_wr || dev_rd)); // R3
    AST_FIXED_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && (fn == FN_FIXED)) |=> $stable(cur_addr)); // R4
    AST_RW_STEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && (fn == FN_INC_RW)) |=> (cur_addr == DATA_W'($past(cur_addr) + DATA_W'(1)))); // R5
    AST_WR_ONLY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && (fn == FN_INC_WR) && !op_wr_q) |=> $stable(cur_addr)); // R6
endmodule

// File: rtl/indirect_devreg_bridge.sv
// Module: indirect_devreg_bridge
// Top level: joins the control word, the per-device pointer store and the
// request sequencer. The device number and register address on the device
// port come straight from the control word and the selected pointer; they
// are steady for the whole of an open access because requests are dropped
// while busy.
module indirect_devreg_bridge #(
    parameter int DEV_W    = idb_pkg::DEV_W,
    parameter int DATA_W   = idb_pkg::DATA_W,
    parameter int IDX_W    = idb_pkg::IDX_W,
    parameter int CTRL_IDX = 13,
    parameter int DATA_IDX = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  mgmt_addr,
    input  logic [DATA_W-1:0] mgmt_wdata,
    input  logic              mgmt_wr,
    input  logic              mgmt_rd,
    output logic [DATA_W-1:0] mgmt_rdata,
    output logic              mgmt_done,
    output logic              mgmt_busy,
    output logic [DEV_W-1:0]  dev_sel,
    output logic [DATA_W-1:0] dev_reg,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic              dev_ack,
    input  logic [DATA_W-1:0] dev_rdata
);
    import idb_pkg::*;

    fn_e               fn;
    logic [DEV_W-1:0]  dev;
    logic [DATA_W-1:0] ctrl_value, cur_addr, st_val;
    logic              ctrl_wr_en, st_upd;

    idb_ctrl_reg #(.DEV_W(DEV_W), .DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr_en),
        .fn_in    (mgmt_wdata[DATA_W-1:DATA_W-2]),
        .dev_in   (mgmt_wdata[DEV_W-1:0]),
        .fn       (fn),
        .dev      (dev),
        .rd_value (ctrl_value)
    );

    idb_addr_store #(.DEV_W(DEV_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (dev),
        .upd     (st_upd),
        .upd_val (st_val),
        .cur     (cur_addr)
    );

    idb_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W),
              .CTRL_IDX(CTRL_IDX), .DATA_IDX(DATA_IDX)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mgmt_addr  (mgmt_addr),
        .mgmt_wdata (mgmt_wdata),
        .mgmt_wr    (mgmt_wr),
        .mgmt_rd    (mgmt_rd),
        .mgmt_rdata (mgmt_rdata),
        .mgmt_done  (mgmt_done),
        .mgmt_busy  (mgmt_busy),
        .fn         (fn),
        .ctrl_value (ctrl_value),
        .cur_addr   (cur_addr),
        .ctrl_wr_en (ctrl_wr_en),
        .st_upd     (st_upd),
        .st_val     (st_val),
        .dev_wr     (dev_wr),
        .dev_rd     (dev_rd),
        .dev_wdata  (dev_wdata),
        .dev_ack    (dev_ack),
        .dev_rdata  (dev_rdata)
    );

    // Device port addressing follows the control word and selected pointer.
    always_comb begin
        dev_sel = dev;
        dev_reg = cur_addr;
    end
endmodule

// File: tb/indirect_devreg_bridge_bench.sv
module indirect_devreg_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic        mgmt_wr = 1'b0, mgmt_rd = 1'b0;
    logic [15:0] mgmt_rdata;
    logic        mgmt_done, mgmt_busy;
    logic [4:0]  dev_sel;
    logic [15:0] dev_reg, dev_wdata;
    logic        dev_wr, dev_rd;
    logic        dev_ack = 1'b0;
    logic [15:0] dev_rdata = '0;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    // Last strobe seen on the device port.
    logic [4:0]  rec_dev;
    logic [15:0] rec_reg, rec_wd;
    logic        rec_wr;

    always #4 clk = ~clk;  // 125 MHz

    indirect_devreg_bridge u_indirect_devreg_bridge (
        .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
        .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd), .mgmt_rdata(mgmt_rdata),
        .mgmt_done(mgmt_done), .mgmt_busy(mgmt_busy), .dev_sel(dev_sel),
        .dev_reg(dev_reg), .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .dev_rdata(dev_rdata)
    );

    function automatic logic [15:0] model(input logic [4:0] d, input logic [15:0] r);
        return r ^ {d, 11'h2A5};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One management access; acts as the device, acknowledging dly cycles
    // after the strobe. Optionally pushes a control write while busy.
    task automatic mgmt_op(input bit wr, input logic [4:0] idx, input logic [15:0] wd,
                           input int dly, input bit intrude,
                           output logic [15:0] rd, output int nstrobe, output int ncyc);
        int waitcnt;
        bit seen;
        @(negedge clk);
        mgmt_addr = idx; mgmt_wdata = wd; mgmt_wr = wr; mgmt_rd = !wr;
        @(posedge clk);
        @(negedge clk);
        mgmt_wr = 1'b0; mgmt_rd = 1'b0;
        nstrobe = 0; ncyc = 1; waitcnt = -1; rd = '0; seen = 1'b0;
        for (int g = 0; g < 40; g++) begin
            dev_ack = 1'b0;
            mgmt_wr = 1'b0;
            if (dev_wr || dev_rd) begin
                nstrobe++;
                rec_dev = dev_sel; rec_reg = dev_reg; rec_wr = dev_wr; rec_wd = dev_wdata;
                waitcnt = dly;
                if (intrude) begin
                    mgmt_addr = 5'h0D; mgmt_wdata = 16'h0015; mgmt_wr = 1'b1;
                end
            end
            if (mgmt_done) begin
                rd = mgmt_rdata; seen = 1'b1;
                break;
            end
            if (waitcnt == 0) begin
                dev_ack = 1'b1; dev_rdata = model(rec_dev, rec_reg); waitcnt = -1;
            end else if (waitcnt > 0) begin
                waitcnt--;
            end
            @(negedge clk);
            ncyc++;
        end
        dev_ack = 1'b0; mgmt_wr = 1'b0;
        if (!seen) check("R8", "completion never seen", 0, 1);
    endtask

    task automatic wr_reg(input logic [4:0] idx, input logic [15:0] v);
        logic [15:0] r; int s, c;
        mgmt_op(1'b1, idx, v, 0, 1'b0, r, s, c);
    endtask

    task automatic rd_reg(input logic [4:0] idx, output logic [15:0] v);
        int s, c;
        mgmt_op(1'b0, idx, '0, 0, 1'b0, v, s, c);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R9", "done low after reset", mgmt_done, 0);
        check("R9", "busy low after reset", mgmt_busy, 0);
        rd_reg(5'h0D, v); check("R9", "control word after reset", v, 16'h0000);
        rd_reg(5'h0E, v); check("R9", "device 0 pointer after reset", v, 16'h0000);
    endtask

    task automatic t_ctrl();
        logic [15:0] r; int s, c;
        mgmt_op(1'b1, 5'h0D, 16'hFFFF, 0, 1'b0, r, s, c);
        check("R2", "control write cycles", c, 1);
        mgmt_op(1'b0, 5'h0D, '0, 0, 1'b0, r, s, c);
        check("R1", "control readback gap bits zero", r, 16'hC01F);
        check("R2", "control read cycles", c, 1);
        wr_reg(5'h0D, 16'h4005); rd_reg(5'h0D, r);
        check("R1", "control readback", r, 16'h4005);
    endtask

    task automatic t_other();
        logic [15:0] r; int s, c;
        wr_reg(5'h0D, 16'h0002);
        mgmt_op(1'b1, 5'h03, 16'hABCD, 0, 1'b0, r, s, c);
        check("R10", "other index write no strobe", s, 0);
        rd_reg(5'h03, r); check("R10", "other index reads zero", r, 16'h0000);
        rd_reg(5'h0D, r); check("R10", "control untouched", r, 16'h0002);
        rd_reg(5'h0E, r); check("R10", "pointer untouched", r, 16'h0000);
    endtask

    task automatic t_addr_mode();
        logic [15:0] r; int s, c;
        wr_reg(5'h0D, 16'h0007);
        mgmt_op(1'b1, 5'h0E, 16'h1234, 0, 1'b0, r, s, c);
        check("R3", "pointer load no strobe", s, 0);
        check("R2", "pointer load cycles", c, 1);
        mgmt_op(1'b0, 5'h0E, '0, 0, 1'b0, r, s, c);
        check("R3", "pointer readback", r, 16'h1234);
        check("R3", "pointer read no strobe", s, 0);
        wr_reg(5'h0D, 16'h0008); rd_reg(5'h0E, r);
        check("R7", "device 8 pointer separate", r, 16'h0000);
        wr_reg(5'h0E, 16'hBEEF);
        wr_reg(5'h0D, 16'h0007); rd_reg(5'h0E, r);
        check("R7", "device 7 pointer kept", r, 16'h1234);
    endtask

    task automatic t_fixed();
        logic [15:0] r; int s, c;
        wr_reg(5'h0D, 16'h4007);
        mgmt_op(1'b0, 5'h0E, '0, 2, 1'b0, r, s, c);
        check("R4", "one strobe on read", s, 1);
        check("R4", "strobe device", rec_dev, 5'd7);
        check("R4", "strobe address", rec_reg, 16'h1234);
        check("R4", "read strobe type", rec_wr, 0);
        check("R8", "read data", r, model(5'd7, 16'h1234));
        check("R8", "read cycles with delay 2", c, 4);
        mgmt_op(1'b1, 5'h0E, 16'h5555, 0, 1'b0, r, s, c);
        check("R4", "one strobe on write", s, 1);
        check("R4", "write strobe type", rec_wr, 1);
        check("R4", "write data", rec_wd, 16'h5555);
        check("R4", "write address unchanged", rec_reg, 16'h1234);
        check("R8", "write cycles with delay 0", c, 2);
        wr_reg(5'h0D, 16'h0007); rd_reg(5'h0E, r);
        check("R4", "pointer kept", r, 16'h1234);
    endtask

    task automatic t_inc_rw();
        logic [15:0] r; int s, c;
        wr_reg(5'h0D, 16'h0009); wr_reg(5'h0E, 16'hFFFE);
        wr_reg(5'h0D, 16'h8009);
        mgmt_op(1'b0, 5'h0E, '0, 1, 1'b0, r, s, c);
        check("R5", "first read address", rec_reg, 16'hFFFE);
        mgmt_op(1'b1, 5'h0E, 16'h0101, 0, 1'b0, r, s, c);
        check("R5", "write after read step", rec_reg, 16'hFFFF);
        mgmt_op(1'b0, 5'h0E, '0, 0, 1'b0, r, s, c);
        check("R5", "wrap to zero", rec_reg, 16'h0000);
        wr_reg(5'h0D, 16'h0009); rd_reg(5'h0E, r);
        check("R5", "pointer after three steps", r, 16'h0001);
    endtask

    task automatic t_inc_wr();
        logic [15:0] r; int s, c;
        wr_reg(5'h0D, 16'h000A); wr_reg(5'h0E, 16'h0100);
        wr_reg(5'h0D, 16'hC00A);
        mgmt_op(1'b0, 5'h0E, '0, 0, 1'b0, r, s, c);
        check("R6", "read address", rec_reg, 16'h0100);
        mgmt_op(1'b0, 5'h0E, '0, 0, 1'b0, r, s, c);
        check("R6", "read keeps pointer", rec_reg, 16'h0100);
        mgmt_op(1'b1, 5'h0E, 16'h7777, 0, 1'b0, r, s, c);
        check("R6", "write address", rec_reg, 16'h0100);
        mgmt_op(1'b0, 5'h0E, '0, 0, 1'b0, r, s, c);
        check("R6", "write steps pointer", rec_reg, 16'h0101);
    endtask

    task automatic t_busy();
        logic [15:0] r; int s, c;
        wr_reg(5'h0D, 16'h4003);
        mgmt_op(1'b0, 5'h0E, '0, 3, 1'b1, r, s, c);
        check("R8", "single strobe while busy", s, 1);
        check("R8", "cycles with delay 3", c, 5);
        rd_reg(5'h0D, r);
        check("R8", "request while busy ignored", r, 16'h4003);
    endtask

    task automatic t_reset_again();
        logic [15:0] r;
        do_reset();
        rd_reg(5'h0D, r); check("R9", "control cleared", r, 16'h0000);
        wr_reg(5'h0D, 16'h0009); rd_reg(5'h0E, r);
        check("R9", "device 9 pointer cleared", r, 16'h0000);
        wr_reg(5'h0D, 16'h0007); rd_reg(5'h0E, r);
        check("R9", "device 7 pointer cleared", r, 16'h0000);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ctrl();
        t_other();
        t_addr_mode();
        t_fixed();
        t_inc_rw();
        t_inc_wr();
        t_busy();
        t_reset_again();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule